// File: doc/BRIEF.md
# Eight-Way Memory Bank Decoder

This block sits between a processor's address bus and the memories of an eight-bit home computer. Each access is assigned to one of five physical regions: main RAM, BASIC ROM, KERNAL ROM, character ROM or the I/O window. It also produces the access's offset inside that region. The processor selects one of eight maps by writing a byte to its on-chip port. Only the low three bits of that byte are kept.

The address space is split into sixteen 4 KB pages, numbered by address bits 15:12. Reads and writes are decoded through separate page tables. A page that shows ROM on a read still passes a write to the RAM underneath. The I/O window, when it is mapped, captures both directions.

A patch mode lets one fixed KERNAL location return a trap opcode instead of its stored byte. The outputs are registered. The decode for an access presented in one cycle appears after the next rising clock edge.

Top module: `bank_decoder`

## Requirements
- R1: Reset is synchronous and active high. While reset is asserted, the outputs are map_sel = 0 (RAM), map_offset = 0, patch_hit = 0 and subst_op = 0. The map configuration returns to 7.
- R2: When port_we is high at a rising edge, the configuration becomes port_din[2:0]. Bits 7:3 have no effect on the map.
- R3: The page is bus_addr[15:12]. A write (bus_wr = 1) decodes to I/O (map_sel = 4) on page 13 when the configuration is 5, 6 or 7. Every other write decodes to RAM (map_sel = 0).
- R4: Reads in configurations 0 and 4 decode to RAM on all sixteen pages.
- R5: Reads of pages 10 and 11 decode to BASIC ROM (map_sel = 1) in configurations 3 and 7. In every other configuration they decode to RAM.
- R6: Reads of pages 14 and 15 decode to KERNAL ROM (map_sel = 2) when configuration bit 1 is set (configurations 2, 3, 6, 7). Otherwise they decode to RAM.
- R7: Reads of page 13 decode as follows: character ROM (map_sel = 3) in configurations 1, 2 and 3, I/O (map_sel = 4) in configurations 5, 6 and 7, and RAM in configurations 0 and 4. Pages 0 to 9 and 12 always decode to RAM.
- R8: map_offset is the address minus the region base. The bases are $0000 for RAM, $A000 for BASIC, $E000 for KERNAL, and $D000 for character ROM and I/O.
- R9: patch_hit = 1 and subst_op = TRAP_OP (default $02) only when all of these hold: the access is a read, patch_en is set, the address is $E388, and the address decodes to KERNAL. In every other case patch_hit = 0 and subst_op = 0.
- R10: Outputs for an access appear one clock edge after it is presented. A port write in cycle n does not affect an access in cycle n. It applies to accesses from cycle n+1 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_we | input | 1 | Write strobe for the processor port configuration |
| port_din | input | 8 | Byte written to the processor port |
| bus_addr | input | 16 | Processor address |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| patch_en | input | 1 | Enables trap-opcode substitution |
| map_sel | output | 3 | Region: 0 RAM, 1 BASIC, 2 KERNAL, 3 character ROM, 4 I/O |
| map_offset | output | 16 | Offset of the access inside the selected region |
| patch_hit | output | 1 | Substitution is active for this access |
| subst_op | output | 8 | Trap opcode when patch_hit, else zero |

## Verification
The bench walks every configuration through all sixteen pages in both directions. The low address bits change from page to page, so this one sweep separates read decode from write decode and shows that each region's offset base is right. Port bytes with junk in bits 7:3 show that only the low three bits are kept.

A port write issued in the same cycle as an access shows that the new map starts one cycle later. Patch probes vary one condition at a time around $E388: a neighbouring address, patch_en cleared, a write, and a map without KERNAL. This shows that substitution needs every condition at once. A behavioural model in the bench predicts each output cycle by cycle.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  typedef enum logic [2:0] {
    REG_RAM    = 3'd0,
    REG_BASIC  = 3'd1,
    REG_KERNAL = 3'd2,
    REG_CHAR   = 3'd3,
    REG_IO     = 3'd4
  } region_e;
endpackage

// File: rtl/bank_cfg_reg.sv
module bank_cfg_reg #(
  parameter int DIN_W     = 8,
  parameter int CFG_W     = 3,
  parameter int RESET_CFG = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [DIN_W-1:0] din,
  output logic [CFG_W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= CFG_W'(RESET_CFG);
    else if (we) cfg <= din[CFG_W-1:0];
  end
endmodule

// File: rtl/bank_page_map.sv
module bank_page_map
  import bank_dec_pkg::*;
#(
  parameter int CFG_W        = 3,
  parameter int PAGE_W       = 4,
  parameter int BASIC_PAGE   = 10,
  parameter int BASIC_PAGES  = 2,
  parameter int HOLE_PAGE    = 13,
  parameter int KERNAL_PAGE  = 14,
  parameter int KERNAL_PAGES = 2
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic [PAGE_W-1:0] page,
  input  logic              is_write,
  output region_e           region
);
  localparam int NCFG  = 1 << CFG_W;
  localparam int NPAGE = 1 << PAGE_W;

  // Mode bits: bit1 exposes KERNAL, bits[1:0]==3 add BASIC,
  // bits[1:0]!=0 open the page-13 hole, bit2 picks I/O over char ROM there.
  function automatic region_e rd_class(int c, int p);
    logic hole_open, kern_on, basic_on, io_on;
    hole_open = (c & 3) != 0;
    kern_on   = (c & 2) != 0;
    basic_on  = (c & 3) == 3;
    io_on     = (c & 4) != 0;
    if (p >= BASIC_PAGE && p < BASIC_PAGE + BASIC_PAGES)
      return basic_on ? REG_BASIC : REG_RAM;
    if (p >= KERNAL_PAGE && p < KERNAL_PAGE + KERNAL_PAGES)
      return kern_on ? REG_KERNAL : REG_RAM;
    if (p == HOLE_PAGE && hole_open)
      return io_on ? REG_IO : REG_CHAR;
    return REG_RAM;
  endfunction

  function automatic region_e wr_class(int c, int p);
    if (p == HOLE_PAGE && (c & 3) != 0 && (c & 4) != 0) return REG_IO;
    return REG_RAM;
  endfunction

  region_e rd_tbl [NCFG][NPAGE];
  region_e wr_tbl [NCFG][NPAGE];

  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    for (genvar p = 0; p < NPAGE; p++) begin : g_page
      assign rd_tbl[c][p] = rd_class(c, p);
      assign wr_tbl[c][p] = wr_class(c, p);
    end
  end

  assign region = is_write ? wr_tbl[cfg][page] : rd_tbl[cfg][page];
endmodule

// File: rtl/bank_offset.sv
module bank_offset
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 4,
  parameter int BASIC_PAGE  = 10,
  parameter int HOLE_PAGE   = 13,
  parameter int KERNAL_PAGE = 14
) (
  input  region_e           region,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] offset
);
  localparam int OFS_W = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] BASIC_BASE  = ADDR_W'(BASIC_PAGE  << OFS_W);
  localparam logic [ADDR_W-1:0] HOLE_BASE   = ADDR_W'(HOLE_PAGE   << OFS_W);
  localparam logic [ADDR_W-1:0] KERNAL_BASE = ADDR_W'(KERNAL_PAGE << OFS_W);

  logic [ADDR_W-1:0] base;
  always_comb begin
    unique case (region)
      REG_BASIC:        base = BASIC_BASE;
      REG_KERNAL:       base = KERNAL_BASE;
      REG_CHAR, REG_IO: base = HOLE_BASE;
      default:          base = '0;
    endcase
  end

  assign offset = addr - base;
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_dec_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter int              PAGE_W       = 4,
  parameter int              CFG_W        = 3,
  parameter int              DIN_W        = 8,
  parameter int              RESET_CFG    = 7,
  parameter int              BASIC_PAGE   = 10,
  parameter int              BASIC_PAGES  = 2,
  parameter int              HOLE_PAGE    = 13,
  parameter int              KERNAL_PAGE  = 14,
  parameter int              KERNAL_PAGES = 2,
  parameter logic [15:0]     PATCH_ADDR   = 16'hE388,
  parameter logic [7:0]      TRAP_OP      = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_we,
  input  logic [DIN_W-1:0]  port_din,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              patch_en,
  output logic [2:0]        map_sel,
  output logic [ADDR_W-1:0] map_offset,
  output logic              patch_hit,
  output logic [7:0]        subst_op
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  logic [CFG_W-1:0]  cfg_q;
  region_e           region_d;
  logic [ADDR_W-1:0] offset_d;
  logic              hit_d;

  bank_cfg_reg #(
    .DIN_W(DIN_W), .CFG_W(CFG_W), .RESET_CFG(RESET_CFG)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(port_we), .din(port_din), .cfg(cfg_q)
  );

  bank_page_map #(
    .CFG_W(CFG_W), .PAGE_W(PAGE_W),
    .BASIC_PAGE(BASIC_PAGE), .BASIC_PAGES(BASIC_PAGES),
    .HOLE_PAGE(HOLE_PAGE),
    .KERNAL_PAGE(KERNAL_PAGE), .KERNAL_PAGES(KERNAL_PAGES)
  ) u_map (
    .cfg(cfg_q), .page(bus_addr[ADDR_W-1:OFS_W]), .is_write(bus_wr),
    .region(region_d)
  );

  bank_offset #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BASIC_PAGE(BASIC_PAGE),
    .HOLE_PAGE(HOLE_PAGE), .KERNAL_PAGE(KERNAL_PAGE)
  ) u_ofs (
    .region(region_d), .addr(bus_addr), .offset(offset_d)
  );

  assign hit_d = !bus_wr && patch_en && (region_d == REG_KERNAL) &&
                 (bus_addr == ADDR_W'(PATCH_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      map_sel    <= 3'(REG_RAM);
      map_offset <= '0;
      patch_hit  <= 1'b0;
      subst_op   <= '0;
    end else begin
      map_sel    <= 3'(region_d);
      map_offset <= offset_d;
      patch_hit  <= hit_d;
      subst_op   <= hit_d ? TRAP_OP : 8'h00;
    end
  end
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int CFG_W  = 3,
  parameter int DIN_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              port_we,
  input logic [DIN_W-1:0]  port_din,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [2:0]        map_sel,
  input logic [ADDR_W-1:0] map_offset,
  input logic              patch_hit,
  input logic [CFG_W-1:0]  cfg
);
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  AST_RESET_OUTS: assert property (@(posedge clk)
    $past(rst) |-> (map_sel == 3'd0 && map_offset == '0 && !patch_hit)); // R1

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(port_we) |-> cfg == $past(port_din[CFG_W-1:0])); // R2

  AST_WRITE_RAM_OR_IO: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(bus_wr) |-> (map_sel == 3'd0 || map_sel == 3'd4)); // R3

  AST_ALLRAM_MODES: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(cfg[1:0]) == 2'b00) |-> map_sel == 3'd0); // R4

  AST_RAM_OFFSET: assert property (@(posedge clk) disable iff (rst || !primed)
    (map_sel == 3'd0) |-> map_offset == $past(bus_addr)); // R8

  AST_PATCH_READ_ONLY: assert property (@(posedge clk) disable iff (rst || !primed)
    patch_hit |-> (map_sel == 3'd2 && !$past(bus_wr))); // R9
endmodule

bind bank_decoder bank_decoder_chk #(
  .ADDR_W(ADDR_W), .CFG_W(CFG_W), .DIN_W(DIN_W)
) u_chk (
  .clk(clk), .rst(rst), .port_we(port_we), .port_din(port_din),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .map_sel(map_sel),
  .map_offset(map_offset), .patch_hit(patch_hit), .cfg(cfg_q)
);

// File: tb/bank_decoder_bench.sv
module bank_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_we = 1'b0;
  logic [7:0]  port_din = 8'h00;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic        patch_en = 1'b0;
  logic [2:0]  map_sel;
  logic [15:0] map_offset;
  logic        patch_hit;
  logic [7:0]  subst_op;

  int checks = 0;
  int errors = 0;
  int cfg_m  = 7;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bank_decoder u_bank_decoder (
    .clk(clk), .rst(rst), .port_we(port_we), .port_din(port_din),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .patch_en(patch_en),
    .map_sel(map_sel), .map_offset(map_offset),
    .patch_hit(patch_hit), .subst_op(subst_op)
  );

  // Behavioural reference: region from configuration, page and direction.
  function automatic int ref_region(int c, int a, bit w);
    int pg = a / 4096;
    if (w) return (pg == 13 && c >= 5) ? 4 : 0;
    case (pg)
      10, 11: return (c == 3 || c == 7) ? 1 : 0;
      14, 15: return (c == 2 || c == 3 || c == 6 || c == 7) ? 2 : 0;
      13: begin
        if (c >= 1 && c <= 3) return 3;
        if (c >= 5) return 4;
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  function automatic int ref_base(int r);
    case (r)
      1: return 'hA000;
      2: return 'hE000;
      3, 4: return 'hD000;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(int c, int a, bit w);
    int pg = a / 4096;
    if (w) return "R3";
    if (c == 0 || c == 4) return "R4";
    if (pg == 10 || pg == 11) return "R5";
    if (pg >= 14) return "R6";
    if (pg == 13) return "R7";
    return "R8";
  endfunction

  task automatic compare(string tag, int e_sel, int e_ofs, bit e_hit);
    int e_op = e_hit ? 'h02 : 0;
    checks++;
    if (map_sel !== 3'(e_sel) || map_offset !== 16'(e_ofs) ||
        patch_hit !== e_hit || subst_op !== 8'(e_op)) begin
      errors++;
      $display("FAIL %s: sel=%0d ofs=%h hit=%0b op=%h expected sel=%0d ofs=%h hit=%0b op=%h",
               tag, map_sel, map_offset, patch_hit, subst_op,
               e_sel, 16'(e_ofs), e_hit, 8'(e_op));
    end
  endtask

  // One bus cycle: drive at negedge, predict with the current model
  // configuration, check just after the following rising edge.
  task automatic step(bit we, int din, int a, bit w, bit pe, string tag);
    int r, o;
    bit h;
    @(negedge clk);
    port_we  = we;
    port_din = 8'(din);
    bus_addr = 16'(a);
    bus_wr   = w;
    patch_en = pe;
    r = ref_region(cfg_m, a, w);
    o = (a - ref_base(r)) & 'hFFFF;
    h = !w && pe && r == 2 && a == 'hE388;
    @(posedge clk);
    if (we) cfg_m = din % 8;
    #1;
    compare(tag, r, o, h);
  endtask

  initial begin
    // R1: reset values while reset is held
    bus_addr = 16'hA123;
    repeat (2) @(posedge clk);
    #1;
    compare("R1", 0, 0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    // R1: configuration after reset is 7 (BASIC visible)
    step(0, 0, 'hA123, 0, 0, "R1");
    step(0, 0, 'hE001, 0, 0, "R1");

    // Sweep all configurations, pages and directions (R2..R8)
    for (int c = 0; c < 8; c++) begin
      step(1, ((c * 5 + 3) << 3) | c, 'h0042, 0, 0, "R2");
      for (int p = 0; p < 16; p++) begin
        for (int w = 0; w < 2; w++) begin
          int a = p * 4096 + ((p * 257 + w * 33 + c * 7) & 'hFFF);
          step(0, 0, a, w[0], 0, tag_for(c, a, w[0]));
        end
      end
    end

    // R2: upper port bits ignored: $F9 selects configuration 1
    step(1, 'hF9, 'h0000, 0, 0, "R2");
    step(0, 0, 'hD000, 0, 0, "R2");
    step(0, 0, 'hA000, 0, 0, "R2");

    // R10: write to port and access in the same cycle uses the old map
    step(1, 'h07, 'hA555, 0, 0, "R10");
    step(0, 0, 'hA555, 0, 0, "R10");

    // R8: boundary offsets under configuration 7
    step(0, 0, 'hBFFF, 0, 0, "R8");
    step(0, 0, 'hDFFF, 0, 0, "R8");
    step(0, 0, 'hFFFF, 0, 0, "R8");
    step(0, 0, 'hCFFF, 0, 0, "R8");
    step(0, 0, 'h9FFF, 0, 0, "R8");
    step(0, 0, 'hD000, 1, 0, "R8");

    // R9: patch substitution conditions
    step(0, 0, 'hE388, 0, 1, "R9");
    step(0, 0, 'hE389, 0, 1, "R9");
    step(0, 0, 'hE388, 0, 0, "R9");
    step(0, 0, 'hE388, 1, 1, "R9");
    step(1, 'h05, 'hE388, 0, 1, "R9");
    step(0, 0, 'hE388, 0, 1, "R9");
    step(1, 'h02, 'h0000, 0, 0, "R9");
    step(0, 0, 'hE388, 0, 1, "R9");

    // R1: reset mid-run restores configuration 7
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    compare("R1", 0, 0, 1'b0);
    cfg_m = 7;
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 'hB010, 0, 0, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule